// File: doc/BRIEF.md
# Microcoded Two-Bus Data Path

This block is the 32-bit execution path of a microprogrammed processor. In every clock cycle a decoded control word chooses one register to drive the B bus. It sets up the ALU, whose left operand is a holding register H and whose right operand is the B bus. It picks a shifter option and names the destination registers that load the shifted result from the C bus on the closing clock edge. Two flags hold the sign and the zero state of the ALU output. These flags are captured on every edge and are meant for the next-address logic of an outside sequencer.

Two memory ports hang off the path. The word port reads and writes whole words, addressed by the word-address register and carrying data in the memory data register. The fetch port is read-only and addressed in bytes by the program counter, and it returns a single byte into an 8-bit buffer register. That byte can drive the B bus zero-extended or sign-extended. A request raised in cycle k is presented to memory in cycle k+1, together with the address the same edge may have just loaded. The returned data lands at the end of cycle k+1, so it can be used from cycle k+2. The control store, the sequencer and the memory itself sit outside the block.

Top module: `dp32_core`

## Requirements
- R1: After reset every 32-bit register and the byte buffer hold zero, and the memory strobes `mem_rd`, `mem_wr` and `fetch_rd` are low.
- R2: `b_sel` codes 0 to 8 put onto the B bus, in order: memory data register, program counter, byte buffer sign-extended, byte buffer zero-extended, SP, LV, CPP, TOS, OPC. Codes 9 to 15 put zero onto the bus.
- R3: With code 3, bits 31:8 of the B bus are zero. With code 2, bits 31:8 copy bit 7 of the byte buffer. Bits 7:0 are the buffer in both cases.
- R4: `alu_fn` bits 5:4 pick the function (00 AND, 01 OR, 10 NOT B, 11 ADD). Bit 3 enables the left input H, bit 2 enables the B input, bit 1 inverts the gated left input, and bit 0 is a carry into the adder. A disabled input reads as zero.
- R5: `sh_fn` bit 1 shifts the ALU output left by 8 and takes precedence over bit 0. Bit 0 alone shifts it right by one arithmetically. With 00 the output passes unchanged. The shifted value is `c_bus`.
- R6: Every register whose `c_en` bit is set loads `c_bus` on the closing edge. Several registers may load at once, and a register that drives the B bus may load the result computed from itself in the same cycle.
- R7: `flag_n` and `flag_z` show bit 31 of the unshifted ALU output, and whether that output was zero, from the previous cycle. They are updated on every edge.
- R8: `rd_req` in cycle k makes `mem_rd` high in cycle k+1, with `mem_addr` equal to the word-address register as loaded at the end of cycle k. `mem_rdata` loads the memory data register at the end of cycle k+1, taking priority over a C-bus write to it at that edge. Reads of that register in cycle k+1 still give the old value.
- R9: `fetch_req` in cycle k makes `fetch_rd` high in cycle k+1, with `fetch_addr` equal to the program counter as loaded at the end of cycle k. `fetch_byte` loads the byte buffer at the end of cycle k+1.
- R10: `wr_req` in cycle k makes `mem_wr` high in cycle k+1. In that cycle `mem_addr` shows the word-address register and `mem_wdata` shows the memory data register.
- R11: `c_en` bit positions are 0 word address, 1 memory data, 2 program counter, 3 SP, 4 LV, 5 CPP, 6 TOS, 7 OPC, 8 H. A register whose bit is clear keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| b_sel | input | 4 | Encoded B bus source |
| alu_fn | input | 6 | ALU function and operand control |
| sh_fn | input | 2 | Shifter control |
| c_en | input | 9 | Destination write enables from the C bus |
| rd_req | input | 1 | Start a word read |
| wr_req | input | 1 | Start a word write |
| fetch_req | input | 1 | Start a byte fetch |
| mem_addr | output | 32 | Word address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_rdata | input | 32 | Word read data, valid while `mem_rd` is high |
| fetch_addr | output | 32 | Byte address of the fetch |
| fetch_rd | output | 1 | Fetch strobe |
| fetch_byte | input | 8 | Fetched byte, valid while `fetch_rd` is high |
| c_bus | output | 32 | Shifter output of the current cycle |
| flag_n | output | 1 | Latched sign of the ALU output |
| flag_z | output | 1 | Latched zero state of the ALU output |

## Verification
Three result latencies are checked. `c_bus` is due in the same cycle as its control word. The flags and the memory strobes with their address and data are due one cycle later. Data brought in by a read or a fetch is seen on `c_bus` two cycles after the request, when a later control word selects the loaded register. Each check is queued with the absolute cycle in which it is due. A monitor compares it at the falling edge of that cycle, and any item left past its cycle counts as missed. The old-value read in cycle k+1 and the lost C-bus write at the load edge are checked in their own cycles.

// File: rtl/dp32_pkg.sv
package dp32_pkg;
  localparam int BSEL_W = 4;
  localparam int NSRC   = 9;
  localparam int NDST   = 9;

  typedef enum logic [BSEL_W-1:0] {
    BS_MDR  = 4'd0,
    BS_PC   = 4'd1,
    BS_MBRS = 4'd2,
    BS_MBRU = 4'd3,
    BS_SP   = 4'd4,
    BS_LV   = 4'd5,
    BS_CPP  = 4'd6,
    BS_TOS  = 4'd7,
    BS_OPC  = 4'd8
  } bsrc_e;

  localparam int CI_MAR = 0;
  localparam int CI_MDR = 1;
  localparam int CI_PC  = 2;
  localparam int CI_SP  = 3;
  localparam int CI_LV  = 4;
  localparam int CI_CPP = 5;
  localparam int CI_TOS = 6;
  localparam int CI_OPC = 7;
  localparam int CI_H   = 8;

  typedef enum logic [1:0] {FN_AND, FN_OR, FN_NOTB, FN_ADD} afn_e;

  typedef struct packed {
    afn_e fsel;
    logic ena;
    logic enb;
    logic inva;
    logic inc;
  } alu_ctl_t;

  localparam int ALU_W = $bits(alu_ctl_t);
endpackage

// File: rtl/dp32_rsync.sv
module dp32_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dp32_bsel.sv
module dp32_bsel
  import dp32_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [BSEL_W-1:0] sel,
  input  logic [DW-1:0]     mdr,
  input  logic [DW-1:0]     pc,
  input  logic [BW-1:0]     mbr,
  input  logic [DW-1:0]     sp,
  input  logic [DW-1:0]     lv,
  input  logic [DW-1:0]     cpp,
  input  logic [DW-1:0]     tos,
  input  logic [DW-1:0]     opc,
  output logic [DW-1:0]     bbus
);
  localparam int XW = DW - BW;

  logic [DW-1:0] src    [NSRC];
  logic [DW-1:0] masked [NSRC];

  assign src[int'(BS_MDR)]  = mdr;
  assign src[int'(BS_PC)]   = pc;
  assign src[int'(BS_MBRS)] = {{XW{mbr[BW-1]}}, mbr};
  assign src[int'(BS_MBRU)] = {{XW{1'b0}}, mbr};
  assign src[int'(BS_SP)]   = sp;
  assign src[int'(BS_LV)]   = lv;
  assign src[int'(BS_CPP)]  = cpp;
  assign src[int'(BS_TOS)]  = tos;
  assign src[int'(BS_OPC)]  = opc;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_dec
    assign masked[gi] = (sel == BSEL_W'(gi)) ? src[gi] : '0;
  end

  always_comb begin
    bbus = '0;
    for (int i = 0; i < NSRC; i++) bbus = bbus | masked[i];
  end
endmodule

// File: rtl/dp32_alu.sv
module dp32_alu
  import dp32_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHL = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_ctl_t      ctl,
  input  logic [1:0]    sh,
  output logic [DW-1:0] y,
  output logic [DW-1:0] shout,
  output logic          neg,
  output logic          zero
);
  logic [DW-1:0] a_g;
  logic [DW-1:0] b_g;
  logic [DW-1:0] a_i;

  always_comb begin
    a_g = ctl.ena ? a : '0;
    b_g = ctl.enb ? b : '0;
    a_i = ctl.inva ? ~a_g : a_g;
    unique case (ctl.fsel)
      FN_AND:  y = a_i & b_g;
      FN_OR:   y = a_i | b_g;
      FN_NOTB: y = ~b_g;
      default: y = a_i + b_g + DW'(ctl.inc);
    endcase
  end

  always_comb begin
    if (sh[1])      shout = y << SHL;
    else if (sh[0]) shout = {y[DW-1], y[DW-1:1]};
    else            shout = y;
  end

  assign neg  = y[DW-1];
  assign zero = (y == '0);
endmodule

// File: rtl/dp32_regs.sv
module dp32_regs
  import dp32_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            c_bus,
  input  logic [NDST-1:0]          c_en,
  input  logic                     mdr_load,
  input  logic [DW-1:0]            mdr_in,
  input  logic                     mbr_load,
  input  logic [BW-1:0]            mbr_in,
  input  logic                     n_in,
  input  logic                     z_in,
  output logic [NDST-1:0][DW-1:0]  q,
  output logic [BW-1:0]            mbr_q,
  output logic                     flag_n,
  output logic                     flag_z
);
  logic [NDST-1:0][DW-1:0] d;
  logic [NDST-1:0]         ce;
  logic [BW-1:0]           mbr_d;
  logic                    mbr_ce;

  always_comb begin
    for (int i = 0; i < NDST; i++) begin
      d[i]  = c_bus;
      ce[i] = c_en[i];
    end
    if (mdr_load) begin
      d[CI_MDR]  = mdr_in;
      ce[CI_MDR] = 1'b1;
    end
    mbr_d  = mbr_in;
    mbr_ce = mbr_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      mbr_q  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      for (int i = 0; i < NDST; i++) begin
        if (ce[i]) q[i] <= d[i];
      end
      if (mbr_ce) mbr_q <= mbr_d;
      flag_n <= n_in;
      flag_z <= z_in;
    end
  end
endmodule

// File: rtl/dp32_memif.sv
module dp32_memif (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  input  logic fetch_req,
  output logic rd_pend,
  output logic wr_pend,
  output logic fe_pend
);
  logic [2:0] pend_q;
  logic [2:0] pend_d;

  always_comb pend_d = {fetch_req, wr_req, rd_req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign rd_pend = pend_q[0];
  assign wr_pend = pend_q[1];
  assign fe_pend = pend_q[2];
endmodule

// File: rtl/dp32_core.sv
module dp32_core
  import dp32_pkg::*;
#(
  parameter int DW  = 32,
  parameter int BW  = 8,
  parameter int SHL = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BSEL_W-1:0]    b_sel,
  input  logic [ALU_W-1:0]     alu_fn,
  input  logic [1:0]           sh_fn,
  input  logic [NDST-1:0]      c_en,
  input  logic                 rd_req,
  input  logic                 wr_req,
  input  logic                 fetch_req,
  output logic [DW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_rd,
  output logic                 mem_wr,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        fetch_addr,
  output logic                 fetch_rd,
  input  logic [BW-1:0]        fetch_byte,
  output logic [DW-1:0]        c_bus,
  output logic                 flag_n,
  output logic                 flag_z
);
  logic                    srst_n;
  logic [NDST-1:0][DW-1:0] rq;
  logic [BW-1:0]           mbr_q;
  logic [DW-1:0]           b_bus;
  logic [DW-1:0]           alu_y;
  logic                    alu_n;
  logic                    alu_z;
  logic                    rd_pend;
  logic                    wr_pend;
  logic                    fe_pend;
  alu_ctl_t                actl;

  assign actl = alu_ctl_t'(alu_fn);

  dp32_rsync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dp32_bsel #(.DW(DW), .BW(BW)) u_bsel (
    .sel  (b_sel),
    .mdr  (rq[CI_MDR]),
    .pc   (rq[CI_PC]),
    .mbr  (mbr_q),
    .sp   (rq[CI_SP]),
    .lv   (rq[CI_LV]),
    .cpp  (rq[CI_CPP]),
    .tos  (rq[CI_TOS]),
    .opc  (rq[CI_OPC]),
    .bbus (b_bus)
  );

  dp32_alu #(.DW(DW), .SHL(SHL)) u_alu (
    .a     (rq[CI_H]),
    .b     (b_bus),
    .ctl   (actl),
    .sh    (sh_fn),
    .y     (alu_y),
    .shout (c_bus),
    .neg   (alu_n),
    .zero  (alu_z)
  );

  dp32_memif u_memif (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .fetch_req (fetch_req),
    .rd_pend   (rd_pend),
    .wr_pend   (wr_pend),
    .fe_pend   (fe_pend)
  );

  dp32_regs #(.DW(DW), .BW(BW)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .c_bus    (c_bus),
    .c_en     (c_en),
    .mdr_load (rd_pend),
    .mdr_in   (mem_rdata),
    .mbr_load (fe_pend),
    .mbr_in   (fetch_byte),
    .n_in     (alu_n),
    .z_in     (alu_z),
    .q        (rq),
    .mbr_q    (mbr_q),
    .flag_n   (flag_n),
    .flag_z   (flag_z)
  );

  assign mem_addr   = rq[CI_MAR];
  assign mem_wdata  = rq[CI_MDR];
  assign fetch_addr = rq[CI_PC];
  assign mem_rd     = rd_pend;
  assign mem_wr     = wr_pend;
  assign fetch_rd   = fe_pend;
endmodule

// File: rtl/dp32_core_chk.sv
module dp32_core_chk
  import dp32_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic              fetch_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              fetch_rd,
  input logic [DW-1:0]     mem_rdata,
  input logic [DW-1:0]     mem_wdata,
  input logic [BSEL_W-1:0] b_sel,
  input logic [DW-1:0]     b_bus,
  input logic [DW-1:0]     alu_y,
  input logic              flag_n,
  input logic              flag_z
);
  logic armed_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_rd_issue_r8: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q && rd_req |=> mem_rd);
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q && !rd_req |=> !mem_rd);
  p_mdr_load_r8: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q && mem_rd |=> (mem_wdata == $past(mem_rdata)));
  p_wr_issue_r10: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q && wr_req |=> mem_wr);
  p_fetch_issue_r9: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q && fetch_req |=> fetch_rd);
  p_zflag_r7: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q |=> (flag_z == ($past(alu_y) == '0)));
  p_nflag_r7: assert property (@(posedge clk) disable iff (!srst_n)
    armed_q |=> (flag_n == $past(alu_y[DW-1])));
  p_bzero_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (b_sel > BSEL_W'(int'(BS_OPC))) |-> (b_bus == '0));
  p_mbru_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (b_sel == BS_MBRU) |-> (b_bus[DW-1:BW] == '0));
  p_mbrs_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (b_sel == BS_MBRS) |-> (b_bus[DW-1:BW] == {(DW-BW){b_bus[BW-1]}}));
endmodule

bind dp32_core dp32_core_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .fetch_req (fetch_req),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .fetch_rd  (fetch_rd),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .b_sel     (b_sel),
  .b_bus     (b_bus),
  .alu_y     (alu_y),
  .flag_n    (flag_n),
  .flag_z    (flag_z)
);

// File: tb/dp32_core_bench.sv
module dp32_core_bench;
  localparam logic [3:0] B_MDR = 4'd0, B_PC = 4'd1, B_MBRS = 4'd2, B_MBRU = 4'd3,
                         B_SP = 4'd4, B_LV = 4'd5, B_CPP = 4'd6, B_TOS = 4'd7, B_OPC = 4'd8;
  localparam logic [8:0] C_NONE = 9'h000, C_MAR = 9'h001, C_MDR = 9'h002, C_PC = 9'h004,
                         C_SP = 9'h008, C_LV = 9'h010, C_CPP = 9'h020, C_TOS = 9'h040,
                         C_OPC = 9'h080, C_H = 9'h100;
  localparam logic [5:0] PASSB = 6'b110100, INCB = 6'b110101, ADD = 6'b111100,
                         ADD1 = 6'b111101, SUB = 6'b111111, DECB = 6'b110110,
                         AND_ = 6'b001100, OR_ = 6'b011100, NOTB = 6'b100100,
                         ZERO = 6'b110000, ONE = 6'b110001, NEG1 = 6'b110010;
  localparam int K_CB = 0, K_N = 1, K_Z = 2, K_RD = 3, K_WR = 4, K_FE = 5, K_IDLE = 6;

  typedef struct {
    int          at;
    int          kind;
    logic [31:0] v;
    logic [31:0] v2;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  b_sel = '0;
  logic [5:0]  alu_fn = ZERO;
  logic [1:0]  sh_fn = '0;
  logic [8:0]  c_en = '0;
  logic        rd_req = 1'b0, wr_req = 1'b0, fetch_req = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fetch_addr, c_bus;
  logic        mem_rd, mem_wr, fetch_rd, flag_n, flag_z;
  logic [7:0]  fetch_byte;
  logic [31:0] wmem [64];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  exp_t        sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mw(int i);
    logic [31:0] t;
    t = 32'(i + 1);
    return 32'h9E3779B9 * t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) wmem[i] <= mw(i);
    end else if (mem_wr) begin
      wmem[mem_addr[5:0]] <= mem_wdata;
    end
  end

  assign mem_rdata  = wmem[mem_addr[5:0]];
  assign fetch_byte = 8'(wmem[fetch_addr[7:2]] >> {fetch_addr[1:0], 3'b000});

  dp32_core u_dp32_core (
    .clk(clk), .rst_n(rst_n), .b_sel(b_sel), .alu_fn(alu_fn), .sh_fn(sh_fn),
    .c_en(c_en), .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .fetch_addr(fetch_addr), .fetch_rd(fetch_rd),
    .fetch_byte(fetch_byte), .c_bus(c_bus), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic op(input logic [3:0] b, input logic [5:0] a, input logic [1:0] s,
                    input logic [8:0] c, input logic rd, input logic wr, input logic fe);
    @(posedge clk);
    #1;
    b_sel = b; alu_fn = a; sh_fn = s; c_en = c;
    rd_req = rd; wr_req = wr; fetch_req = fe;
  endtask

  task automatic exp(input int off, input int kind, input logic [31:0] v,
                     input logic [31:0] v2, input string tag);
    exp_t e;
    e.at = cyc + off; e.kind = kind; e.v = v; e.v2 = v2; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic judge(input exp_t e);
    logic        ok;
    logic [63:0] act, want;
    want = {e.v2, e.v};
    case (e.kind)
      K_CB:   begin act = {32'h0, c_bus};  want = {32'h0, e.v}; end
      K_N:    begin act = {63'h0, flag_n}; want = {32'h0, e.v}; end
      K_Z:    begin act = {63'h0, flag_z}; want = {32'h0, e.v}; end
      K_RD:   begin act = {31'h0, mem_rd, mem_addr};   want = {32'h1, e.v}; end
      K_FE:   begin act = {31'h0, fetch_rd, fetch_addr}; want = {32'h1, e.v}; end
      K_WR:   begin act = mem_wr ? {mem_wdata, mem_addr} : 64'hDEAD; end
      default: begin act = {61'h0, mem_rd, mem_wr, fetch_rd}; want = 64'h0; end
    endcase
    ok = (act == want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d kind %0d actual %h expected %h", e.tag, cyc, e.kind, act, want);
    end
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        judge(sb[i]);
        sb.delete(i);
      end else if (sb[i].at < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed check due in cycle %0d actual none expected %h", sb[i].tag, sb[i].at, sb[i].v);
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int s = 0; s < 9; s++) begin
      op(4'(s), PASSB, 2'b00, C_NONE, 0, 0, 0); exp(0, K_CB, 32'h0, 0, "R1");
    end
    exp(0, K_IDLE, 0, 0, "R1");

    // R4, R6 multiple destinations and read-modify-write
    op(B_MDR, ONE, 2'b00, C_SP | C_LV, 0, 0, 0); exp(0, K_CB, 32'h1, 0, "R4");
    op(B_SP, PASSB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h1, 0, "R6");
    op(B_LV, PASSB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h1, 0, "R6");
    op(B_SP, INCB, 2'b00, C_SP, 0, 0, 0);        exp(0, K_CB, 32'h2, 0, "R4");
    op(B_SP, PASSB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h2, 0, "R6");

    // R5 left shift, R2 TOS source
    op(B_SP, PASSB, 2'b10, C_TOS, 0, 0, 0);      exp(0, K_CB, 32'h200, 0, "R5");
    op(B_TOS, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, 32'h200, 0, "R2");

    // R4 functions with H = -1, R7 flags
    op(B_MDR, NEG1, 2'b00, C_H, 0, 0, 0);        exp(0, K_CB, 32'hFFFFFFFF, 0, "R4");
    exp(1, K_N, 1, 0, "R7"); exp(1, K_Z, 0, 0, "R7");
    op(B_TOS, ADD, 2'b00, C_NONE, 0, 0, 0);      exp(0, K_CB, 32'h1FF, 0, "R4");
    exp(1, K_N, 0, 0, "R7");
    op(B_TOS, SUB, 2'b00, C_NONE, 0, 0, 0);      exp(0, K_CB, 32'h201, 0, "R4");
    op(B_TOS, AND_, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h200, 0, "R4");
    op(B_TOS, OR_, 2'b00, C_NONE, 0, 0, 0);      exp(0, K_CB, 32'hFFFFFFFF, 0, "R4");
    op(B_TOS, NOTB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'hFFFFFDFF, 0, "R4");
    op(B_TOS, DECB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h1FF, 0, "R4");
    op(B_TOS, ADD1, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h200, 0, "R4");

    // R5 right shift and precedence, R7 flags come from unshifted output
    op(B_MDR, ONE, 2'b01, C_NONE, 0, 0, 0);      exp(0, K_CB, 32'h0, 0, "R5");
    exp(1, K_Z, 0, 0, "R7");
    op(B_MDR, NEG1, 2'b01, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'hFFFFFFFF, 0, "R5");
    op(B_SP, PASSB, 2'b11, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h200, 0, "R5");
    op(B_MDR, ZERO, 2'b00, C_NONE, 0, 0, 0);     exp(1, K_Z, 1, 0, "R7");

    // R8 word read: MAR = 2
    op(B_SP, PASSB, 2'b00, C_MAR, 1, 0, 0);      exp(1, K_RD, 32'h2, 0, "R8");
    op(B_MDR, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, 32'h0, 0, "R8");
    op(B_MDR, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, mw(2), 0, "R8");

    // R8 memory load wins over C-bus write: MAR = 1
    op(B_MDR, ONE, 2'b00, C_MAR, 1, 0, 0);       exp(1, K_RD, 32'h1, 0, "R8");
    op(B_TOS, PASSB, 2'b00, C_MDR, 0, 0, 0);     exp(0, K_CB, 32'h200, 0, "R8");
    op(B_MDR, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, mw(1), 0, "R8");

    // R10 word write to address 1, then read back
    op(B_TOS, PASSB, 2'b00, C_MDR, 0, 0, 0);
    op(B_LV, PASSB, 2'b00, C_MAR, 0, 1, 0);      exp(1, K_WR, 32'h1, 32'h200, "R10");
    op(B_MDR, ZERO, 2'b00, C_NONE, 1, 0, 0);     exp(1, K_RD, 32'h1, 0, "R10");
    op(B_MDR, ZERO, 2'b00, C_MDR, 0, 0, 0);
    op(B_MDR, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, 32'h200, 0, "R10");

    // R9 fetch byte 0 (0xB9), R3 extensions
    op(B_MDR, ZERO, 2'b00, C_PC, 0, 0, 1);       exp(1, K_FE, 32'h0, 0, "R9");
    op(B_MBRS, PASSB, 2'b00, C_NONE, 0, 0, 0);   exp(0, K_CB, 32'h0, 0, "R9");
    op(B_MBRS, PASSB, 2'b00, C_NONE, 0, 0, 0);   exp(0, K_CB, 32'hFFFFFFB9, 0, "R3");
    op(B_MBRU, PASSB, 2'b00, C_NONE, 0, 0, 0);   exp(0, K_CB, 32'h000000B9, 0, "R3");
    op(B_LV, PASSB, 2'b00, C_PC, 0, 0, 1);       exp(1, K_FE, 32'h1, 0, "R9");
    op(B_MDR, ZERO, 2'b00, C_NONE, 0, 0, 0);
    op(B_MBRS, PASSB, 2'b00, C_NONE, 0, 0, 0);   exp(0, K_CB, 32'h00000079, 0, "R3");
    op(B_PC, PASSB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h1, 0, "R2");
    exp(0, K_IDLE, 0, 0, "R9");

    // R11 CPP/OPC write and H via adder
    op(B_TOS, INCB, 2'b00, C_CPP | C_OPC, 0, 0, 0); exp(0, K_CB, 32'h201, 0, "R11");
    op(B_CPP, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, 32'h201, 0, "R11");
    op(B_OPC, ADD, 2'b00, C_NONE, 0, 0, 0);      exp(0, K_CB, 32'h200, 0, "R11");

    // R11 registers with clear enables hold
    op(B_MDR, NEG1, 2'b00, C_NONE, 0, 0, 0);
    op(B_SP, PASSB, 2'b00, C_NONE, 0, 0, 0);     exp(0, K_CB, 32'h2, 0, "R11");
    op(B_TOS, PASSB, 2'b00, C_NONE, 0, 0, 0);    exp(0, K_CB, 32'h200, 0, "R11");

    // R2 unused codes read as zero
    for (int s = 9; s < 16; s++) begin
      op(4'(s), PASSB, 2'b00, C_NONE, 0, 0, 0);  exp(0, K_CB, 32'h0, 0, "R2");
    end

    op(B_MDR, ZERO, 2'b00, C_NONE, 0, 0, 0);
    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule